// File: doc/BRIEF.md
# Delayed-Capture Thermometer Read Latch

This block sits behind a seven-comparator resistance ladder in a multi-level resistive memory read path. While a read pulse is applied, the comparators produce a thermometer pattern that fills from bit 0 upward. Once the pulse is removed, that pattern falls back to all zeros. The latch converts the pattern to a 3-bit binary read value. It takes the sample a programmable number of clock cycles after the read-pulse strobe rises, which gives the analog path time to settle. It then holds the sampled value after the pulse and the comparator outputs have gone away.

A controller sets `delay_cfg_i`, raises `read_en_i` and drives `strobe_i` high for the length of the read pulse. Each successful capture produces a one-cycle `valid_o` strobe. A pulse that ends before the delay has elapsed produces no capture and a one-cycle `short_err_o` strobe instead. While `read_en_i` is low (programming mode), the read value shown at the port is forced to zero.

The control is a three-state machine:
- IDLE waits for a rising strobe edge while read mode is on (transition IDLE->WAIT loads the delay timer).
- WAIT counts the delay. It has three exits:
  - WAIT->HELD captures when the timer expires with the strobe still high.
  - WAIT->IDLE flags a short pulse when the strobe is seen low.
  - WAIT->IDLE abandons silently when read mode drops.
- HELD waits for the strobe to fall, or for read mode to drop, and then moves HELD->IDLE.

Top module: `thermo_read_latch`

## Requirements
- R1: The read value is the number of ones in `therm_i` in binary, with `code_o[0]` the LSB and `code_o[2]` the MSB. For example, 0000001 gives 001 and 0011111 gives 101. Non-monotonic patterns are encoded by the same count of ones.
- R2: Let edge t0 be the first clock edge at which `strobe_i` is sampled high after being low, with `read_en_i` high. With a delay setting D≥1, the value of `therm_i` sampled at edge t0+D is captured. `valid_o` is high for exactly the one cycle following that edge.
- R3: A delay setting of 0 behaves exactly like a setting of 1.
- R4: The captured value stays on `code_o` after the strobe falls and the comparator bits return to zero. It changes only at the next capture or at reset.
- R5: If `strobe_i` is sampled low at any edge t0+k with 1≤k≤D, nothing is captured. `short_err_o` is high for the one cycle after that edge, and `code_o` keeps its previous value.
- R6: While `read_en_i` is low, `code_o` is 000 and `valid_o` is low. The held value is kept and reappears when `read_en_i` returns high.
- R7: A strobe rise while `read_en_i` is low is ignored. If `read_en_i` drops during the delay, the read is abandoned with neither a capture nor an error.
- R8: After reset, `code_o` is 000 and `valid_o` and `short_err_o` are low.
- R9: One strobe pulse yields at most one capture, however long it stays high. A new capture needs a new rising edge.
- R10: `valid_o` and `short_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| read_en_i | input | 1 | High selects read mode; low selects programming mode |
| strobe_i | input | 1 | Read-pulse strobe, high while the pulse is applied |
| therm_i | input | 7 | Comparator outputs, thermometer coded |
| delay_cfg_i | input | DLY_W (8) | Capture delay in clock cycles after the strobe edge |
| code_o | output | 3 | Held binary read value |
| valid_o | output | 1 | One-cycle strobe marking a new capture |
| short_err_o | output | 1 | One-cycle strobe marking a pulse shorter than the delay |

## Verification
The bench counts edges from the first edge at which the strobe is high. It expects the new value and `valid_o` in the cycle after edge D, and `short_err_o` in the cycle after the first edge that sees the strobe low within the delay window. All outputs are sampled on the falling clock edge, and `valid_o`, `short_err_o` and `code_o` are compared in every cycle of every pulse, so an output that comes early or late by one cycle is caught. Because `code_o` is gated by `read_en_i` without a register in between, the bench samples it on the falling edge that follows the change of mode.

// File: rtl/thermo_read_pkg.sv
package thermo_read_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HELD = 2'd2
    } rd_state_t;

endpackage

// File: rtl/thermo_popcount_enc.sv
module thermo_popcount_enc #(
    parameter int THERM_W = 7,
    localparam int CODE_W = $clog2(THERM_W + 1)
) (
    input  logic [THERM_W-1:0] therm_i,
    output logic [CODE_W-1:0]  code_o
);

    // Chain of partial sums; tolerant of bubbles in the thermometer pattern.
    logic [CODE_W-1:0] psum [THERM_W+1];

    assign psum[0] = '0;

    for (genvar g = 0; g < THERM_W; g++) begin : g_sum
        assign psum[g+1] = psum[g] + CODE_W'(therm_i[g]);
    end

    assign code_o = psum[THERM_W];

endmodule

// File: rtl/capture_delay_timer.sv
module capture_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/read_capture_fsm.sv
module read_capture_fsm
    import thermo_read_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic read_en_i,
    input  logic strobe_i,
    input  logic expired_i,
    output logic load_o,
    output logic run_o,
    output logic capture_o,
    output logic short_o
);

    rd_state_t state_q, state_d;
    logic      strobe_q;
    logic      strobe_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
        end
    end

    assign strobe_rise = strobe_i && !strobe_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        load_o    = 1'b0;
        run_o     = 1'b0;
        capture_o = 1'b0;
        short_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (read_en_i && strobe_rise) begin
                    load_o  = 1'b1;
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                run_o = 1'b1;
                if (!read_en_i) begin
                    state_d = ST_IDLE;
                end else if (!strobe_i) begin
                    short_o = 1'b1;
                    state_d = ST_IDLE;
                end else if (expired_i) begin
                    capture_o = 1'b1;
                    state_d   = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!strobe_i || !read_en_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/thermo_read_latch.sv
module thermo_read_latch #(
    parameter int THERM_W = 7,
    parameter int DLY_W   = 8,
    localparam int CODE_W = $clog2(THERM_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               read_en_i,
    input  logic               strobe_i,
    input  logic [THERM_W-1:0] therm_i,
    input  logic [DLY_W-1:0]   delay_cfg_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               valid_o,
    output logic               short_err_o
);

    logic [CODE_W-1:0] enc_code;
    logic [DLY_W-1:0]  load_val;
    logic              t_load, t_run, t_expired;
    logic              do_capture, do_short;
    logic [CODE_W-1:0] hold_q;
    logic              valid_q, short_q;

    thermo_popcount_enc #(.THERM_W(THERM_W)) u_enc (
        .therm_i (therm_i),
        .code_o  (enc_code)
    );

    // A setting of zero is treated as one cycle; the timer counts D-1 down to zero.
    assign load_val = (delay_cfg_i == '0) ? '0 : (delay_cfg_i - 1'b1);

    capture_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (load_val),
        .run_i      (t_run),
        .expired_o  (t_expired)
    );

    read_capture_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_en_i (read_en_i),
        .strobe_i  (strobe_i),
        .expired_i (t_expired),
        .load_o    (t_load),
        .run_o     (t_run),
        .capture_o (do_capture),
        .short_o   (do_short)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
            short_q <= 1'b0;
        end else begin
            valid_q <= do_capture;
            short_q <= do_short;
            if (do_capture) begin
                hold_q <= enc_code;
            end
        end
    end

    assign code_o      = read_en_i ? hold_q : '0;
    assign valid_o     = valid_q && read_en_i;
    assign short_err_o = short_q;

endmodule

// File: rtl/thermo_read_latch_chk.sv
module thermo_read_latch_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              read_en_i,
    input logic              strobe_i,
    input logic [CODE_W-1:0] code_o,
    input logic              valid_o,
    input logic              short_err_o
);

    assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en_i |-> (code_o == '0) && !valid_o);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && short_err_o));

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        short_err_o |=> !short_err_o);

    assert_valid_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(strobe_i));

    assert_err_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        short_err_o |-> !$past(strobe_i));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en_i && $past(read_en_i) && $past(rst_n) && !valid_o) |-> $stable(code_o));

endmodule

bind thermo_read_latch thermo_read_latch_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .read_en_i   (read_en_i),
    .strobe_i    (strobe_i),
    .code_o      (code_o),
    .valid_o     (valid_o),
    .short_err_o (short_err_o)
);

// File: tb/tb_thermo_read_latch.sv
module tb_thermo_read_latch;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       read_en_i = 1'b0;
    logic       strobe_i = 1'b0;
    logic [6:0] therm_i = '0;
    logic [7:0] delay_cfg_i = 8'd1;
    logic [2:0] code_o;
    logic       valid_o;
    logic       short_err_o;

    int total = 0;
    int bad = 0;
    int hold_exp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_read_latch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_en_i   (read_en_i),
        .strobe_i    (strobe_i),
        .therm_i     (therm_i),
        .delay_cfg_i (delay_cfg_i),
        .code_o      (code_o),
        .valid_o     (valid_o),
        .short_err_o (short_err_o)
    );

    function automatic int ones(input logic [6:0] p);
        int n = 0;
        for (int b = 0; b < 7; b++) n += int'(p[b]);
        return n;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One read pulse, strobe high for len edges, delay setting d.
    task automatic read_pulse(input logic [6:0] pat, input int d, input int len);
        int eff;
        bit cap;
        eff = (d == 0) ? 1 : d;
        cap = (len > eff);
        delay_cfg_i = 8'(d);
        strobe_i = 1'b1;
        therm_i = pat;
        for (int i = 1; i <= len + 3; i++) begin
            @(negedge clk);
            if (cap && i == eff + 1) hold_exp = ones(pat);
            chk("R2/R3/R9 valid timing", int'(valid_o), int'(cap && i == eff + 1));
            chk("R5 short error timing", int'(short_err_o), int'(!cap && i == len + 1));
            chk("R1/R4 held code", int'(code_o), hold_exp);
            if (i == len) begin
                strobe_i = 1'b0;
                therm_i = '0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk("R8 reset code", int'(code_o), 0);
        chk("R8 reset valid", int'(valid_o), 0);
        chk("R8 reset err", int'(short_err_o), 0);
        rst_n = 1'b1;
        read_en_i = 1'b1;
        @(negedge clk);
        chk("R8 code after reset", int'(code_o), 0);

        // Directed encodings: 0000001 -> 001, 0011111 -> 101, bubble, full
        read_pulse(7'b0000001, 3, 6);
        chk("R1 0000001", int'(code_o), 1);
        read_pulse(7'b0011111, 2, 5);
        chk("R1 0011111", int'(code_o), 5);
        read_pulse(7'b0101101, 1, 2);
        chk("R1 bubble", int'(code_o), 4);
        read_pulse(7'b1111111, 4, 12);
        chk("R1 full/R9 long pulse", int'(code_o), 7);
        // R3: zero delay acts as one
        read_pulse(7'b0000111, 0, 2);
        chk("R3 delay zero", int'(code_o), 3);
        // R5: pulse exactly as long as the delay, and a one-edge pulse
        read_pulse(7'b0111111, 5, 5);
        chk("R5 held kept", int'(code_o), 3);
        read_pulse(7'b0000001, 3, 1);

        // R6: programming mode gates the output, value returns after
        read_en_i = 1'b0;
        @(negedge clk);
        chk("R6 code forced low", int'(code_o), 0);
        // R7: strobe rise while read_en low is ignored
        strobe_i = 1'b1;
        therm_i = 7'b1111111;
        delay_cfg_i = 8'd1;
        repeat (4) begin
            @(negedge clk);
            chk("R7 no valid in prog mode", int'(valid_o), 0);
            chk("R7 no err in prog mode", int'(short_err_o), 0);
            chk("R6 code low", int'(code_o), 0);
        end
        strobe_i = 1'b0;
        therm_i = '0;
        @(negedge clk);
        read_en_i = 1'b1;
        @(negedge clk);
        chk("R6 held value returns", int'(code_o), hold_exp);

        // R7: read_en drops during the delay
        delay_cfg_i = 8'd5;
        strobe_i = 1'b1;
        therm_i = 7'b0001111;
        repeat (2) @(negedge clk);
        read_en_i = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk("R7 abandon no valid", int'(valid_o), 0);
            chk("R7 abandon no err", int'(short_err_o), 0);
        end
        read_en_i = 1'b1;
        repeat (2) @(negedge clk);
        strobe_i = 1'b0;
        therm_i = '0;
        repeat (3) begin
            @(negedge clk);
            chk("R7 no late capture", int'(valid_o), 0);
            chk("R7 code unchanged", int'(code_o), hold_exp);
        end

        // Random pulses, bubbles included
        for (int n = 0; n < 300; n++) begin
            logic [6:0] p;
            int d, l, gap;
            p = 7'($urandom);
            if ($urandom_range(1, 0) == 1) p = 7'((1 << $urandom_range(7, 0)) - 1);
            d = $urandom_range(7, 0);
            l = $urandom_range(10, 1);
            read_pulse(p, d, l);
            gap = $urandom_range(3, 0);
            for (int g = 0; g < gap; g++) @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule